// File: doc/BRIEF.md
# Receive Buffer-Ring DMA Engine

This block sits behind the receive side of an Ethernet MAC and moves the bytes of each received frame into a ring of fixed 128-byte memory buffers. The bytes collect in one 128-byte staging store. A chunk is flushed to memory when that store fills, or when the frame ends with fewer bytes pending. A frame longer than one buffer therefore occupies several consecutive ring entries. A minimum-size frame fits in a single entry. The flush uses a plain word-write port of 32-bit words.

Every ring entry carries an ownership bit. The engine claims an entry by filling it and will not write to an entry it still owns. Software reads an entry's descriptor (ownership, first-buffer flag, last-buffer flag and frame length), empties the buffer, and hands the entry back through a release strobe. The engine raises a sticky frame-received flag that software can poll. It can also raise an interrupt on every finished buffer or only on finished frames. If the next entry is still owned when a chunk must be flushed, the engine drops the rest of that frame, raises a sticky overrun flag, and picks up again at the next frame start.

Top module: `rxdma_ring_engine`

## Requirements
- R1: A frame of N bytes fills ceil(N/128) consecutive ring entries. Every entry holds 128 bytes except the last, which holds the remainder. A frame of exactly 128 bytes uses one entry.
- R2: A chunk is flushed when 128 bytes have gathered or when the frame's end marker arrives. Chunk byte i is written to word i/4, bits 8*(i%4)+7 down to 8*(i%4). Unused byte lanes of the final word are zero, and only ceil(bytes/4) words are written.
- R3: A chunk going to entry e is written as words e*32+0, e*32+1, and so on, on consecutive cycles with one write per cycle.
- R4: Ring entries are used in order 0, 1, ..., ringSize-1 and then wrap back to 0. No write ever addresses an entry at or above ringSize.
- R5: An entry becomes owned (descOwned=1) when its chunk has been written. The engine never writes an owned entry. A release strobe with releaseIdx clears that entry's ownership.
- R6: When the entry at the ring head is owned at the moment a chunk must be flushed, that chunk and the rest of its frame are discarded with no memory writes, and overrun becomes 1. The head does not move, and the next frame start is written to that same entry once it is free. overrun is cleared by overrunClr=1, and a new overrun in the same cycle takes priority.
- R7: Each written entry records descSof=1 if it is the first entry of its frame and descEof=1 if it is the last. descLen holds the total frame length in bytes on the last entry and 0 on all others.
- R8: frameRcvd becomes 1 the cycle after the last word of a frame's final entry is written. frameRcvdClr=1 clears it, and a set in the same cycle takes priority.
- R9: With irqEnable=1 and irqPerFrame=0, irq pulses high for one cycle after every completed buffer.
- R10: With irqEnable=1 and irqPerFrame=1, irq follows frameRcvd and drops on the cycle after frameRcvdClr.
- R11: After reset, memWrEn, irq, frameRcvd and overrun are 0 and no entry is owned.
- R12: Bytes that arrive outside a frame (rxValid without a preceding start marker) are ignored and cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringSize | input | 11 | Number of active ring entries, 1..1024; changed only while idle |
| irqEnable | input | 1 | Interrupt enable |
| irqPerFrame | input | 1 | 1: interrupt per frame, 0: per buffer |
| rxValid | input | 1 | A received byte is present |
| rxByte | input | 8 | Received byte |
| rxSof | input | 1 | The byte is the first of a frame |
| rxEof | input | 1 | The byte is the last of a frame |
| memWrEn | output | 1 | Memory word write strobe |
| memAddr | output | 15 | Word address: entry index times 32 plus word |
| memWrData | output | 32 | Word to write, byte 0 in the low lane |
| releaseEn | input | 1 | Return one entry to the engine |
| releaseIdx | input | 10 | Entry being returned |
| descIdx | input | 10 | Entry whose descriptor is shown |
| descOwned | output | 1 | Entry is filled and owned by software |
| descSof | output | 1 | Entry starts a frame |
| descEof | output | 1 | Entry ends a frame |
| descLen | output | 11 | Frame length on the last entry, else 0 |
| frameRcvd | output | 1 | At least one complete frame has been stored |
| frameRcvdClr | input | 1 | Write-one-to-clear for frameRcvd |
| overrun | output | 1 | A frame was dropped for lack of a free entry |
| overrunClr | input | 1 | Write-one-to-clear for overrun |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-formed byte stream. At most one byte arrives per cycle, and a start marker never appears in the middle of a frame. After every end marker there are at least 66 idle cycles, so that a pending tail flush can finish before the next frame overwrites the staging store. They also assume that ringSize changes only while the engine is idle, and that frames are no longer than 2047 bytes. The bench sends each frame one byte per cycle with a 70-cycle idle gap afterwards. It keeps frame lengths between 1 and 600 bytes, fixes ringSize at 16, and has software release only entries it has already checked, except in the deliberate overrun cases.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int BUF_BYTES  = 128;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int BUF_WORDS  = BUF_BYTES / WORD_BYTES;
  localparam int WIDX_W     = $clog2(BUF_WORDS);
  localparam int FILL_W     = WIDX_W + $clog2(WORD_BYTES) + 1;

  // strobes from control to the datapath
  typedef struct packed {
    logic [WIDX_W-1:0] rdWord;
    logic              discard;
  } dpCtrl_t;
endpackage

// File: rtl/rxdma_datapath.sv
module rxdma_datapath import rxdma_pkg::*; #(
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              rxSof,
  input  logic              rxEof,
  input  dpCtrl_t           ctl,
  output logic              closeEv,
  output logic [FILL_W-1:0] closeBytes,
  output logic              closeSof,
  output logic              closeEof,
  output logic [LEN_W-1:0]  closeFrameLen,
  output logic [WORD_W-1:0] rdData
);
  localparam logic [FILL_W-1:0] FILL_ONE  = FILL_W'(1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(BUF_BYTES);
  localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);
  localparam int LANE_W = $clog2(WORD_BYTES);

  logic [WORD_W-1:0] stage [BUF_WORDS];
  logic [FILL_W-1:0] fill, curFill, newFill;
  logic [LEN_W-1:0]  frameCnt, newCnt;
  logic              inFrame, discarding, chunkSof, accept;
  logic [WIDX_W-1:0] wordSel;
  logic [LANE_W-1:0] laneSel;

  always_comb begin
    accept   = rxValid && (rxSof || (inFrame && !discarding));
    curFill  = rxSof ? '0 : fill;
    newFill  = curFill + FILL_ONE;
    newCnt   = rxSof ? LEN_ONE : frameCnt + LEN_ONE;
    wordSel  = curFill[WIDX_W+LANE_W-1:LANE_W];
    laneSel  = curFill[LANE_W-1:0];
    closeEv       = accept && ((newFill == FILL_FULL) || rxEof);
    closeBytes    = newFill;
    closeSof      = rxSof || chunkSof;
    closeEof      = rxEof;
    closeFrameLen = newCnt;
    rdData        = stage[ctl.rdWord];
  end

  // staging store: first lane of a word clears the rest
  always_ff @(posedge clk) begin
    if (accept) begin
      if (laneSel == '0) stage[wordSel] <= {{(WORD_W-8){1'b0}}, rxByte};
      else               stage[wordSel][laneSel*8 +: 8] <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fill       <= '0;
      frameCnt   <= '0;
      inFrame    <= 1'b0;
      discarding <= 1'b0;
      chunkSof   <= 1'b0;
    end else begin
      if (accept) begin
        fill       <= closeEv ? '0 : newFill;
        frameCnt   <= newCnt;
        chunkSof   <= closeEv ? 1'b0 : closeSof;
        inFrame    <= !rxEof;
        discarding <= 1'b0;
      end
      if (ctl.discard && !(accept && rxSof)) begin
        discarding <= 1'b1;
        inFrame    <= 1'b0;
        fill       <= '0;
        chunkSof   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl import rxdma_pkg::*; #(
  parameter int MAX_ENTRIES = 1024,
  parameter int LEN_W       = 11,
  localparam int IDX_W = $clog2(MAX_ENTRIES),
  localparam int CNT_W = IDX_W + 1,
  localparam int AW    = IDX_W + WIDX_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CNT_W-1:0]       ringSize,
  input  logic                   closeEv,
  input  logic [FILL_W-1:0]      closeBytes,
  input  logic                   closeSof,
  input  logic                   closeEof,
  input  logic [LEN_W-1:0]       closeFrameLen,
  input  logic [WORD_W-1:0]      rdData,
  output dpCtrl_t                ctl,
  output logic                   memWrEn,
  output logic [AW-1:0]          memAddr,
  output logic [WORD_W-1:0]      memWrData,
  input  logic                   releaseEn,
  input  logic [IDX_W-1:0]       releaseIdx,
  input  logic [IDX_W-1:0]       descIdx,
  output logic                   descOwned,
  output logic                   descSof,
  output logic                   descEof,
  output logic [LEN_W-1:0]       descLen,
  input  logic                   frameRcvdClr,
  input  logic                   overrunClr,
  output logic                   frameRcvd,
  output logic                   overrun,
  output logic                   bufDone,
  output logic [MAX_ENTRIES-1:0] ownedVec
);
  localparam logic [WIDX_W-1:0] WORD_ONE = WIDX_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [FILL_W-1:0] WORD_BYTES_F = FILL_W'(WORD_BYTES);

  logic                   busy, pend;
  logic [WIDX_W-1:0]      wordCnt;
  logic [IDX_W-1:0]       head, curIdx, nextHead;
  logic [CNT_W-1:0]       headPlus;
  logic [FILL_W-1:0]      curBytes, pBytes, sBytes, wordEnd;
  logic                   curSof, curEof, pSof, pEof, sSof, sEof;
  logic [LEN_W-1:0]       curLen, pLen, sLen;
  logic                   srcValid, startOk, startDrop, finish;
  logic [MAX_ENTRIES-1:0] ownedQ;
  logic                   dSof [MAX_ENTRIES];
  logic                   dEof [MAX_ENTRIES];
  logic [LEN_W-1:0]       dLen [MAX_ENTRIES];

  always_comb begin
    sBytes    = pend ? pBytes : closeBytes;
    sSof      = pend ? pSof   : closeSof;
    sEof      = pend ? pEof   : closeEof;
    sLen      = pend ? pLen   : closeFrameLen;
    srcValid  = !busy && (pend || closeEv);
    startOk   = srcValid && !ownedQ[head];
    startDrop = srcValid && ownedQ[head];
    headPlus  = {1'b0, head} + CNT_ONE;
    nextHead  = (headPlus >= ringSize) ? '0 : headPlus[IDX_W-1:0];
    wordEnd   = {1'b0, wordCnt, 2'b00} + WORD_BYTES_F;
    finish    = busy && (wordEnd >= curBytes);
    ctl.rdWord  = wordCnt;
    ctl.discard = startDrop && !sEof;
    memWrEn   = busy;
    memAddr   = {curIdx, wordCnt};
    memWrData = rdData;
    descOwned = ownedQ[descIdx];
    descSof   = dSof[descIdx];
    descEof   = dEof[descIdx];
    descLen   = dLen[descIdx];
    ownedVec  = ownedQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      pend      <= 1'b0;
      wordCnt   <= '0;
      head      <= '0;
      curIdx    <= '0;
      curBytes  <= '0;
      curSof    <= 1'b0;
      curEof    <= 1'b0;
      curLen    <= '0;
      pBytes    <= '0;
      pSof      <= 1'b0;
      pEof      <= 1'b0;
      pLen      <= '0;
      frameRcvd <= 1'b0;
      overrun   <= 1'b0;
      bufDone   <= 1'b0;
      ownedQ    <= '0;
    end else begin
      if (startOk) begin
        busy     <= 1'b1;
        wordCnt  <= '0;
        curIdx   <= head;
        head     <= nextHead;
        curBytes <= sBytes;
        curSof   <= sSof;
        curEof   <= sEof;
        curLen   <= sLen;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        wordCnt <= wordCnt + WORD_ONE;
      end

      if (closeEv && busy) begin
        pend   <= 1'b1;
        pBytes <= closeBytes;
        pSof   <= closeSof;
        pEof   <= closeEof;
        pLen   <= closeFrameLen;
      end else if (!busy && pend) begin
        pend <= 1'b0;
      end

      if (startDrop)       overrun <= 1'b1;
      else if (overrunClr) overrun <= 1'b0;

      if (finish && curEof)  frameRcvd <= 1'b1;
      else if (frameRcvdClr) frameRcvd <= 1'b0;

      bufDone <= finish;

      if (releaseEn) ownedQ[releaseIdx] <= 1'b0;
      if (finish)    ownedQ[curIdx]     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (finish) begin
      dSof[curIdx] <= curSof;
      dEof[curIdx] <= curEof;
      dLen[curIdx] <= curEof ? curLen : '0;
    end
  end
endmodule

// File: rtl/rxdma_ring_engine.sv
module rxdma_ring_engine import rxdma_pkg::*; #(
  parameter int MAX_ENTRIES = 1024,
  parameter int MAX_FRAME   = 2047,
  localparam int IDX_W = $clog2(MAX_ENTRIES),
  localparam int CNT_W = IDX_W + 1,
  localparam int AW    = IDX_W + WIDX_W,
  localparam int LEN_W = $clog2(MAX_FRAME + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  ringSize,
  input  logic              irqEnable,
  input  logic              irqPerFrame,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              rxSof,
  input  logic              rxEof,
  output logic              memWrEn,
  output logic [AW-1:0]     memAddr,
  output logic [WORD_W-1:0] memWrData,
  input  logic              releaseEn,
  input  logic [IDX_W-1:0]  releaseIdx,
  input  logic [IDX_W-1:0]  descIdx,
  output logic              descOwned,
  output logic              descSof,
  output logic              descEof,
  output logic [LEN_W-1:0]  descLen,
  output logic              frameRcvd,
  input  logic              frameRcvdClr,
  output logic              overrun,
  input  logic              overrunClr,
  output logic              irq
);
  dpCtrl_t                ctl;
  logic                   closeEv, closeSof, closeEof, bufDone;
  logic [FILL_W-1:0]      closeBytes;
  logic [LEN_W-1:0]       closeFrameLen;
  logic [WORD_W-1:0]      rdData;
  logic [MAX_ENTRIES-1:0] ownedVec;

  rxdma_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .rxSof(rxSof), .rxEof(rxEof), .ctl(ctl), .closeEv(closeEv),
    .closeBytes(closeBytes), .closeSof(closeSof), .closeEof(closeEof),
    .closeFrameLen(closeFrameLen), .rdData(rdData)
  );

  rxdma_ctrl #(.MAX_ENTRIES(MAX_ENTRIES), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ringSize(ringSize), .closeEv(closeEv),
    .closeBytes(closeBytes), .closeSof(closeSof), .closeEof(closeEof),
    .closeFrameLen(closeFrameLen), .rdData(rdData), .ctl(ctl),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .releaseEn(releaseEn), .releaseIdx(releaseIdx), .descIdx(descIdx),
    .descOwned(descOwned), .descSof(descSof), .descEof(descEof),
    .descLen(descLen), .frameRcvdClr(frameRcvdClr), .overrunClr(overrunClr),
    .frameRcvd(frameRcvd), .overrun(overrun), .bufDone(bufDone),
    .ownedVec(ownedVec)
  );

  assign irq = irqEnable && (irqPerFrame ? frameRcvd : bufDone);
endmodule

// File: rtl/rxdma_checker.sv
module rxdma_checker import rxdma_pkg::*; #(
  parameter int MAX_ENTRIES = 1024,
  localparam int IDX_W = $clog2(MAX_ENTRIES),
  localparam int CNT_W = IDX_W + 1,
  localparam int AW    = IDX_W + WIDX_W
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   memWrEn,
  input logic [AW-1:0]          memAddr,
  input logic [CNT_W-1:0]       ringSize,
  input logic [MAX_ENTRIES-1:0] ownedVec,
  input logic                   frameRcvd,
  input logic                   frameRcvdClr,
  input logic                   irq,
  input logic                   irqEnable,
  input logic                   irqPerFrame
);
  logic [IDX_W-1:0]  wrIdx;
  logic [WIDX_W-1:0] wrWord;
  assign wrIdx  = memAddr[AW-1:WIDX_W];
  assign wrWord = memAddr[WIDX_W-1:0];

  assert_no_write_owned_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !ownedVec[wrIdx]);

  assert_write_in_ring_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ({1'b0, wrIdx} < ringSize));

  assert_word_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn) && (wrIdx == $past(wrIdx)))
      |-> (wrWord == $past(wrWord) + WIDX_W'(1)));

  assert_frame_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameRcvd) |-> $past(memWrEn));

  assert_frame_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameRcvd) |-> $past(frameRcvdClr));

  assert_buffer_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && irqEnable && !irqPerFrame) |-> $past(memWrEn));
endmodule

bind rxdma_ring_engine rxdma_checker #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .memWrEn(memWrEn), .memAddr(memAddr),
  .ringSize(ringSize), .ownedVec(ownedVec), .frameRcvd(frameRcvd),
  .frameRcvdClr(frameRcvdClr), .irq(irq), .irqEnable(irqEnable),
  .irqPerFrame(irqPerFrame)
);

// File: tb/tb_rxdma_ring_engine.sv
module tb_rxdma_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int RING = 16;
  localparam int GAP  = 70;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [10:0] ringSize = 11'(RING);
  logic irqEnable = 1'b1, irqPerFrame = 1'b0;
  logic rxValid = 1'b0, rxSof = 1'b0, rxEof = 1'b0;
  logic [7:0] rxByte = '0;
  logic memWrEn;
  logic [14:0] memAddr;
  logic [31:0] memWrData;
  logic releaseEn = 1'b0;
  logic [9:0] releaseIdx = '0, descIdx = '0;
  logic descOwned, descSof, descEof;
  logic [10:0] descLen;
  logic frameRcvd, overrun, irq;
  logic frameRcvdClr = 1'b0, overrunClr = 1'b0;

  int total = 0, bad = 0;
  int writeCount = 0, irqPulses = 0, strayWrites = 0;
  int expHead = 0, wraps = 0;
  logic [31:0] memImg [RING*32];

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdma_ring_engine dut (
    .clk(clk), .rstN(rstN), .ringSize(ringSize), .irqEnable(irqEnable),
    .irqPerFrame(irqPerFrame), .rxValid(rxValid), .rxByte(rxByte),
    .rxSof(rxSof), .rxEof(rxEof), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .releaseEn(releaseEn), .releaseIdx(releaseIdx),
    .descIdx(descIdx), .descOwned(descOwned), .descSof(descSof),
    .descEof(descEof), .descLen(descLen), .frameRcvd(frameRcvd),
    .frameRcvdClr(frameRcvdClr), .overrun(overrun), .overrunClr(overrunClr),
    .irq(irq)
  );

  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      writeCount++;
      if (int'(memAddr) < RING*32) memImg[memAddr] = memWrData;
      else strayWrites++;
    end
    if (rstN && irq && !irqPerFrame) irqPulses++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] genByte(input int seed, input int i);
    return 8'((seed * 37) ^ (i * 11) ^ (i >> 5));
  endfunction

  function automatic logic [31:0] expWord(input int seed, input int base, input int nb, input int w);
    logic [31:0] v = '0;
    for (int l = 0; l < 4; l++)
      if (w*4 + l < nb) v[l*8 +: 8] = genByte(seed, base + w*4 + l);
    return v;
  endfunction

  task automatic sendFrame(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxByte = genByte(seed, i);
      rxSof = (i == 0); rxEof = (i == len - 1);
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic releaseEntry(input int idx);
    @(negedge clk); releaseEn = 1'b1; releaseIdx = 10'(idx);
    @(negedge clk); releaseEn = 1'b0;
  endtask

  task automatic clearFrame();
    @(negedge clk); frameRcvdClr = 1'b1;
    @(negedge clk); frameRcvdClr = 1'b0;
  endtask

  task automatic readDesc(input int idx);
    descIdx = 10'(idx); #1;
  endtask

  // checks every entry of one frame starting at expHead, then advances expHead
  task automatic checkFrame(input int len, input int seed, input bit doRelease);
    int chunks = (len + 127) / 128;
    for (int c = 0; c < chunks; c++) begin
      int nb = (len - c*128 > 128) ? 128 : len - c*128;
      int nw = (nb + 3) / 4;
      int errs = 0;
      int firstBad = 0;
      for (int w = 0; w < nw; w++)
        if (memImg[expHead*32 + w] !== expWord(seed, c*128, nb, w)) begin
          if (errs == 0) firstBad = w;
          errs++;
        end
      if (errs != 0)
        check(expHead == 0 && c > 0 ? "R4" : "R2", int'(memImg[expHead*32 + firstBad]),
              int'(expWord(seed, c*128, nb, firstBad)));
      else check(expHead == 0 && c > 0 ? "R4" : "R2", 0, 0);
      readDesc(expHead);
      check("R5", int'(descOwned), 1);
      check("R7", int'(descSof), int'(c == 0));
      check("R7", int'(descEof), int'(c == chunks - 1));
      check("R7", int'(descLen), (c == chunks - 1) ? len : 0);
      if (doRelease) begin
        releaseEntry(expHead);
        readDesc(expHead);
        check("R5", int'(descOwned), 0);
      end
      if (expHead == RING - 1) begin expHead = 0; wraps++; end
      else expHead++;
    end
  endtask

  function automatic int wordsOf(input int len);
    int n = 0;
    for (int c = 0; c*128 < len; c++)
      n += (((len - c*128 > 128) ? 128 : len - c*128) + 3) / 4;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wc, ip, h;
    process::self().srandom(32'd20240531);
    repeat (5) @(negedge clk);
    // R11: state in reset
    check("R11", int'(memWrEn), 0);
    check("R11", int'(irq), 0);
    check("R11", int'(frameRcvd), 0);
    check("R11", int'(overrun), 0);
    readDesc(0); check("R11", int'(descOwned), 0);
    rstN = 1'b1;
    // R12: bytes outside a frame
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rxValid = 1'b1; rxByte = 8'(i); rxEof = (i == 19);
    end
    @(negedge clk); rxValid = 1'b0; rxEof = 1'b0;
    repeat (40) @(negedge clk);
    check("R12", writeCount, 0);
    check("R12", int'(frameRcvd), 0);

    // minimum-size frame, per-buffer interrupt
    ip = irqPulses; wc = writeCount;
    sendFrame(64, 1);
    check("R8", int'(frameRcvd), 1);
    check("R9", irqPulses - ip, 1);
    check("R3", writeCount - wc, 16);
    checkFrame(64, 1, 1'b1);
    clearFrame();
    check("R8", int'(frameRcvd), 0);

    // multi-buffer frame
    ip = irqPulses; wc = writeCount;
    sendFrame(300, 2);
    check("R9", irqPulses - ip, 3);
    check("R1", writeCount - wc, wordsOf(300));
    checkFrame(300, 2, 1'b1);
    clearFrame();

    // per-frame interrupt, short tail with zeroed lanes
    irqPerFrame = 1'b1;
    sendFrame(5, 3);
    check("R10", int'(irq), 1);
    checkFrame(5, 3, 1'b1);
    clearFrame();
    check("R10", int'(irq), 0);
    check("R8", int'(frameRcvd), 0);
    irqPerFrame = 1'b0;

    // exactly one full buffer
    wc = writeCount;
    sendFrame(128, 4);
    check("R1", writeCount - wc, 32);
    checkFrame(128, 4, 1'b1);
    clearFrame();

    // random lengths across several ring wraps
    for (int f = 0; f < 25; f++) begin
      int len = $urandom_range(1, 600);
      int sd = $urandom_range(5, 1000);
      wc = writeCount;
      sendFrame(len, sd);
      check("R1", writeCount - wc, wordsOf(len));
      checkFrame(len, sd, 1'b1);
      clearFrame();
    end
    check("R4", int'(wraps > 0), 1);
    check("R4", strayWrites, 0);

    // overrun: fill the ring without returning entries
    for (int f = 0; f < RING; f++) begin
      sendFrame(100, 50 + f);
      checkFrame(100, 50 + f, 1'b0);
    end
    wc = writeCount;
    sendFrame(200, 90);
    check("R6", int'(overrun), 1);
    check("R6", writeCount - wc, 0);
    @(negedge clk); overrunClr = 1'b1;
    @(negedge clk); overrunClr = 1'b0;
    check("R6", int'(overrun), 0);
    // free only the head: first chunk lands, tail is dropped
    h = expHead;
    releaseEntry(h);
    wc = writeCount;
    sendFrame(200, 91);
    check("R6", writeCount - wc, 32);
    check("R6", int'(overrun), 1);
    readDesc(h);
    check("R6", int'(descOwned), 1);
    check("R6", int'(descSof), 1);
    check("R6", int'(descEof), 0);
    check("R6", int'(memImg[h*32]), int'(expWord(91, 0, 128, 0)));
    // return everything, resume at next frame start
    for (int e = 0; e < RING; e++) releaseEntry(e);
    @(negedge clk); overrunClr = 1'b1;
    @(negedge clk); overrunClr = 1'b0;
    expHead = (h + 1) % RING;
    sendFrame(10, 92);
    check("R6", int'(overrun), 0);
    checkFrame(10, 92, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule